// File: doc/BRIEF.md
# LCD Segment Line Scanner

This block is the refresh engine of a 64-column LCD segment driver. A line counter walks through the 64 display rows. The counter's value plus a programmable start line gives the row to show. On each rising edge of the line clock, the block reads that row out of the display memory and holds it in a 64-bit latch. On each falling edge of the line clock, the line counter moves to the next row. A rising edge of the frame signal returns the counter to row 0. The frame signal keeps the segment scan aligned with the common scan.

The display memory is organised as eight pages. Each page holds 64 column bytes, and each byte covers eight rows. The block presents a page number to the memory and receives all 64 bytes of that page in the same cycle. From each byte it keeps the bit that belongs to the current row. For each column, the latched pixel bit, the alternation phase and the display-enable flag together choose one of four bias levels. The result drives the analog output stage as a 2-bit code.

The line clock and the frame signal are asynchronous to the system clock. The block samples both through a synchronizer and acts on the edges it detects. The memory write path and the analog levels are outside this block.

Top module: `lcd_seg_scan`

## Requirements
- R1: While reset is held (rst_n low), the line counter is 0 and the latch is all zeros. With M low and the display enabled, every segment therefore outputs code 01, and page_sel equals start_line[5:3].
- R2: On a detected rising edge of the line clock, the latch takes, for each column c, bit r[2:0] of byte c from page r[5:3]. Here r = (counter + start_line) mod 64. Byte c is page_bytes[8c+7:8c].
- R3: On a detected falling edge of the line clock, the line counter increments by one and wraps from 63 to 0.
- R4: On a detected rising edge of the frame signal, the counter is preset to 0. This preset takes priority over a falling edge of the line clock detected in the same cycle.
- R5: With M low and the display enabled, a latched 1 selects code 00 (V0) and a latched 0 selects code 01 (V2). Column c drives seg_lvl[2c+1:2c].
- R6: With M high and the display enabled, a latched 1 selects code 11 (V5) and a latched 0 selects code 10 (V3).
- R7: With the display disabled, every column outputs the non-select level for the current M: code 01 for M low, code 10 for M high. The latch contents have no effect.
- R8: The start line offsets the fetched row modulo 64. Each value from 0 to 63 is accepted.
- R9: Between rising edges of the line clock, the latch holds its value, even when the memory contents change.
- R10: page_sel always equals bits [5:3] of (counter + start_line) mod 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cl_in | input | 1 | Line clock (asynchronous) |
| frm_in | input | 1 | Frame sync (asynchronous) |
| m_in | input | 1 | AC alternation phase |
| disp_on | input | 1 | Display enable; 0 forces the non-select level |
| start_line | input | 6 | First displayed row |
| page_sel | output | 3 | Page address to the display memory |
| page_bytes | input | 512 | The 64 column bytes of the selected page |
| seg_lvl | output | 128 | 2-bit level code per column |

## Verification
A counter that skips, fails to wrap or ignores the frame preset shows up at the next line-clock rising edge. From then on, the segment codes of every column come from the wrong memory row. page_sel shows the error at once, because it is combinational from the counter. A latch that reloads outside a rising edge shows up on the first memory change after a latch load. An error in the level mapping shows up on the same cycle that M or the display-enable input changes.

// File: rtl/lcd_seg_pkg.sv
// Package lcd_seg_pkg: shared level codes and the pixel-to-level mapping.
// Assumes a 2-bit code that the analog stage decodes.
package lcd_seg_pkg;

    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V3 = 2'b10,
        LVL_V5 = 2'b11
    } seg_level_t;

    // Pick the bias level from pixel, phase and enable.
    function automatic seg_level_t level_of(input logic pix, input logic phase, input logic on);
        logic lit;
        lit = pix & on;
        if (!phase) return lit ? LVL_V0 : LVL_V2;
        else        return lit ? LVL_V5 : LVL_V3;
    endfunction

endpackage

// File: rtl/sig_edge_detect.sv
// sig_edge_detect: brings an asynchronous input into the clk domain
// through STAGES flops and flags single-cycle rise and fall pulses.
// Assumes the input stays stable for more than STAGES+1 clk cycles.
module sig_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] hist;

    // Shift the input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[STAGES-1:0], din};
    end

    assign rise = hist[STAGES-1] & ~hist[STAGES];
    assign fall = ~hist[STAGES-1] & hist[STAGES];

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rise && fall));

endmodule

// File: rtl/line_counter.sv
// line_counter: the Z line counter. It advances on a line-clock fall and
// presets to 0 on a frame rise; the preset wins. It also forms the fetched
// row as counter + start line, wrapping naturally at ROW_BITS.
module line_counter #(
    parameter int ROW_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                preset,
    input  logic [ROW_BITS-1:0] start_line,
    output logic [ROW_BITS-1:0] row
);
    logic [ROW_BITS-1:0] z;

    // Update the counter: preset first, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)      z <= '0;
        else if (preset) z <= '0;
        else if (step)   z <= z + 1'b1;
    end

    // Offset the counter by the start line, modulo 2**ROW_BITS.
    assign row = z + start_line;

    // R3
    z_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !preset) |=> (z == $past(z) + 1'b1));
    // R4
    z_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (z == '0));
    // R3
    z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !preset) |=> $stable(z));

endmodule

// File: rtl/row_latch.sv
// row_latch: turns the row number into a page address and a bit index,
// then extracts one bit from every column byte. On load it captures
// those bits into the display latch.
// Assumes the memory returns the bytes of page_sel in the same cycle.
module row_latch #(
    parameter int NUM_COLS = 64,
    parameter int BYTE_W   = 8,
    parameter int ROW_BITS = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [ROW_BITS-1:0]        row,
    input  logic [NUM_COLS*BYTE_W-1:0] page_bytes,
    output logic [ROW_BITS-$clog2(BYTE_W)-1:0] page_sel,
    output logic [NUM_COLS-1:0]        bits_q
);
    localparam int BIT_SEL = $clog2(BYTE_W);

    logic [BIT_SEL-1:0]  bit_idx;
    logic [NUM_COLS-1:0] row_bits;

    assign page_sel = row[ROW_BITS-1:BIT_SEL];
    assign bit_idx  = row[BIT_SEL-1:0];

    generate
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            logic [BYTE_W-1:0] col_byte;
            assign col_byte    = page_bytes[c*BYTE_W +: BYTE_W];
            assign row_bits[c] = col_byte[bit_idx];
        end
    endgenerate

    // Capture the addressed row on a line-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)    bits_q <= '0;
        else if (load) bits_q <= row_bits;
    end

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bits_q));

endmodule

// File: rtl/level_map.sv
// level_map: converts each latched pixel bit into a 2-bit bias-level
// code. The code depends on the alternation phase and the display enable.
module level_map
    import lcd_seg_pkg::*;
#(
    parameter int NUM_COLS = 64
) (
    input  logic                  rst_n,
    input  logic [NUM_COLS-1:0]   bits_q,
    input  logic                  m_in,
    input  logic                  disp_on,
    output logic [2*NUM_COLS-1:0] seg_lvl
);
    generate
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_map
            seg_level_t lvl;
            // Select this column's level.
            always_comb lvl = level_of(bits_q[c], m_in, disp_on);
            assign seg_lvl[2*c +: 2] = lvl;

            // Check the column code against phase and enable.
            always_comb begin
                if (rst_n) begin
                    // R5
                    phase_bit_chk: assert (lvl[1] == m_in);
                    // R7
                    if (!disp_on) begin
                        off_level_chk: assert (lvl == (m_in ? LVL_V3 : LVL_V2));
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lcd_seg_scan.sv
// lcd_seg_scan: the refresh side of a segment driver. It synchronizes the
// line clock and the frame signal, keeps the line counter, fetches and
// latches one row per line, and maps each latched bit to a level code.
// Assumes cl_in and frm_in change slowly relative to clk.
module lcd_seg_scan #(
    parameter int NUM_COLS    = 64,
    parameter int BYTE_W      = 8,
    parameter int ROW_BITS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cl_in,
    input  logic                       frm_in,
    input  logic                       m_in,
    input  logic                       disp_on,
    input  logic [ROW_BITS-1:0]        start_line,
    output logic [ROW_BITS-$clog2(BYTE_W)-1:0] page_sel,
    input  logic [NUM_COLS*BYTE_W-1:0] page_bytes,
    output logic [2*NUM_COLS-1:0]      seg_lvl
);
    logic cl_rise, cl_fall, frm_rise, frm_fall_unused;
    logic [ROW_BITS-1:0] row;
    logic [NUM_COLS-1:0] bits_q;

    sig_edge_detect #(.STAGES(SYNC_STAGES)) u_cl_sync (
        .clk(clk), .rst_n(rst_n), .din(cl_in), .rise(cl_rise), .fall(cl_fall));

    sig_edge_detect #(.STAGES(SYNC_STAGES)) u_frm_sync (
        .clk(clk), .rst_n(rst_n), .din(frm_in), .rise(frm_rise), .fall(frm_fall_unused));

    line_counter #(.ROW_BITS(ROW_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(cl_fall), .preset(frm_rise),
        .start_line(start_line), .row(row));

    row_latch #(.NUM_COLS(NUM_COLS), .BYTE_W(BYTE_W), .ROW_BITS(ROW_BITS)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(cl_rise), .row(row),
        .page_bytes(page_bytes), .page_sel(page_sel), .bits_q(bits_q));

    level_map #(.NUM_COLS(NUM_COLS)) u_map (
        .rst_n(rst_n), .bits_q(bits_q), .m_in(m_in), .disp_on(disp_on), .seg_lvl(seg_lvl));

endmodule

// File: tb/sim_lcd_seg_scan.sv
module sim_lcd_seg_scan;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 5;

    logic clk = 0, rst_n = 0, cl_in = 0, frm_in = 0, m_in = 0, disp_on = 1;
    logic [5:0]   start_line = 0;
    logic [2:0]   page_sel;
    logic [511:0] page_bytes;
    logic [127:0] seg_lvl;

    logic [7:0]  mem [8][64];
    logic [63:0] exp_bits = '0;
    int zb = 0;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_seg_scan u0 (.clk(clk), .rst_n(rst_n), .cl_in(cl_in), .frm_in(frm_in),
        .m_in(m_in), .disp_on(disp_on), .start_line(start_line), .page_sel(page_sel),
        .page_bytes(page_bytes), .seg_lvl(seg_lvl));

    // Memory model: returns the selected page at once.
    always_comb
        for (int c = 0; c < 64; c++) page_bytes[c*8 +: 8] = mem[page_sel][c];

    function automatic logic [63:0] row_of(input int r);
        logic [63:0] b;
        for (int c = 0; c < 64; c++) b[c] = mem[r/8][c][r%8];
        return b;
    endfunction

    function automatic logic [127:0] exp_seg(input logic [63:0] b, input logic m, input logic on);
        logic [127:0] v;
        for (int c = 0; c < 64; c++) begin
            if (!on || !b[c]) v[2*c +: 2] = m ? 2'b10 : 2'b01;
            else              v[2*c +: 2] = m ? 2'b11 : 2'b00;
        end
        return v;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_seg(input string req);
        logic [127:0] e;
        e = exp_seg(exp_bits, m_in, disp_on);
        total++;
        if (seg_lvl !== e) begin
            bad++;
            $display("FAIL %s seg_lvl actual=%h expected=%h", req, seg_lvl, e);
        end
    endtask

    task automatic check_page(input string req);
        logic [5:0] r;
        r = 6'(zb + int'(start_line));
        total++;
        if (page_sel !== r[5:3]) begin
            bad++;
            $display("FAIL %s page_sel actual=%0d expected=%0d", req, page_sel, r[5:3]);
        end
    endtask

    // One line-clock period: rise latches the row, fall advances the counter.
    task automatic cl_pulse(input string req);
        cl_in = 1;
        wait_clk(SETTLE);
        exp_bits = row_of((zb + int'(start_line)) % 64);
        check_seg(req);
        cl_in = 0;
        wait_clk(SETTLE);
        zb = (zb + 1) % 64;
    endtask

    task automatic frm_pulse();
        frm_in = 1;
        wait_clk(SETTLE);
        zb = 0;
        frm_in = 0;
        wait_clk(SETTLE);
    endtask

    task automatic fill_random();
        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 64; c++) mem[p][c] = 8'($urandom);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0108));
        fill_random();
        start_line = 6'd13;
        // R1: reset state
        wait_clk(4);
        check_seg("R1");
        check_page("R1");
        rst_n = 1;
        wait_clk(2);

        // R2, R5: first line with M low
        cl_pulse("R2 R5");
        // R6: flip phase, same latch
        m_in = 1; wait_clk(1); check_seg("R6");
        // R7: display off in both phases
        disp_on = 0; wait_clk(1); check_seg("R7 M=1");
        m_in = 0; wait_clk(1); check_seg("R7 M=0");
        disp_on = 1; wait_clk(1); check_seg("R5");

        // R9: memory change without a rising edge is not seen
        for (int c = 0; c < 64; c++) mem[page_sel][c] = ~mem[page_sel][c];
        wait_clk(4); check_seg("R9");
        check_page("R10");

        // R3: walk a full frame plus wrap
        for (int i = 0; i < 70; i++) begin
            cl_pulse("R3");
            check_page("R10");
        end

        // R4: frame preset
        frm_pulse();
        check_page("R4");
        cl_pulse("R4");

        // R4: frame rise together with a line-clock fall; preset wins
        cl_in = 1; wait_clk(SETTLE);
        cl_in = 0; frm_in = 1; wait_clk(SETTLE);
        zb = 0;
        frm_in = 0; wait_clk(SETTLE);
        check_page("R4 simultaneous");
        cl_pulse("R4 simultaneous");

        // R8: start line extremes
        start_line = 6'd63; frm_pulse();
        cl_pulse("R8 start=63");
        cl_pulse("R8 wrap");
        start_line = 6'd0; frm_pulse();
        cl_pulse("R8 start=0");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 9) == 0) fill_random();
            if ($urandom_range(0, 19) == 0) begin
                start_line = 6'($urandom);
                frm_pulse();
            end
            m_in = 1'($urandom);
            disp_on = ($urandom_range(0, 3) != 0);
            cl_pulse("R2 R8 random");
            check_page("R10 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule